// File: doc/BRIEF.md
# Dual-Channel Blink PWM Generator

This block drives two LED dimming or blinking waveforms from one fixed reference clock. A shared divider turns the system clock into a slow tick. Each channel uses that tick to step its own 8-bit prescaler. Each time the prescaler completes, the channel's 8-bit step counter advances by one. One full period of a channel is therefore 256 × (prescaler + 1) ticks. With a tick rate of 256 × 152 Hz, this spans roughly 152 Hz down to about 0.59 Hz. At the fast settings the eye sees a steady brightness set by the duty value. At the slow settings it sees a visible blink.

Each output is active-low, so LED on means the pin is at 0. A channel pulls its pin low while its step counter is below the duty value it is holding, and releases it otherwise. A duty value of zero therefore keeps the LED dark.

The prescaler and duty inputs are sampled only at the start of a period. As a result, a value written in the middle of a period cannot cut a pulse short or stretch it.

Top module: `blink_pwm_pair`

## Requirements
- R1: While the synchronous reset is high, and on the first sample after it falls, every blink output is 1 (off), whatever the setting inputs hold.
- R2: A tick occurs once every TICK_DIV clock cycles after reset, the first one taken at clock edge TICK_DIV. A channel's step counter advances once every (psc + 1) ticks.
- R3: After n ticks (n ≥ 1) with constant settings from reset, the step count is floor(n / (psc + 1)) mod 256. The output is 0 when that count is below the duty value and 1 otherwise.
- R4: A duty value of 0 keeps the output at 1 for every count.
- R5: A duty value of 255 gives an output of 0 for counts 0 to 254 and 1 at count 255.
- R6: The two channels run independently. Each output depends only on its own psc and duty inputs.
- R7: A change of the duty input during a period is ignored until both counters next stand at zero. The new value is sampled on the following tick.
- R8: A change of the psc input during a period is ignored until that same period start.
- R9: With psc = 255 the step count holds each value for 256 ticks.
- R10: Before the first tick after reset, the output is 1 even when the duty input is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| psc_i | input | NUM_CH×8 | Per-channel prescaler setting; period is 256·(psc+1) ticks |
| duty_i | input | NUM_CH×8 | Per-channel duty setting; LED on while the count is below it |
| blink_n_o | output | NUM_CH | Active-low blink levels, one per channel |

## Verification
The bench builds the block with TICK_DIV = 2 and the default two channels. A tick every second clock brings a full 256-step wrap within a few hundred cycles. It also brings the slowest prescaler step, 256 ticks per count, within reach. Vectors reach counts 0, 254, 255 and the wrap back to 0. They also hit both sides of each duty threshold. Directed runs change settings mid-period and check that nothing moves until the next period start.

// File: rtl/blink_pkg.sv
package blink_pkg;

    parameter int unsigned PSC_W  = 8;
    parameter int unsigned DUTY_W = 8;

    typedef logic [PSC_W-1:0]  psc_t;
    typedef logic [DUTY_W-1:0] duty_t;

    // Registered state of one blink channel
    typedef struct packed {
        psc_t  pre_cnt;   // ticks counted within the current step
        duty_t step_cnt;  // position inside the period
        psc_t  pre_lim;   // prescaler value held for this period
        duty_t duty_lim;  // duty value held for this period
        logic  led_n;     // registered active-low output
    } chan_state_t;

endpackage

// File: rtl/blink_tick_gen.sv
module blink_tick_gen #(
    parameter int unsigned TICK_DIV = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);

    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    assign tick_o = (div_q == DIV_LAST);

    always_comb begin
        div_d = div_q;
        if (tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/blink_channel.sv
module blink_channel
    import blink_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    input  psc_t  psc_i,
    input  duty_t duty_i,
    output logic  led_n_o,
    output duty_t step_o,
    output duty_t duty_lim_o
);

    chan_state_t st_d, st_q;
    logic        at_start;
    psc_t        lim_now;

    // A period starts when both counters rest at zero
    assign at_start = (st_q.pre_cnt == '0) && (st_q.step_cnt == '0);
    assign lim_now  = at_start ? psc_i : st_q.pre_lim;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (at_start) begin
                st_d.pre_lim  = psc_i;
                st_d.duty_lim = duty_i;
            end
            if (st_q.pre_cnt == lim_now) begin
                st_d.pre_cnt  = '0;
                st_d.step_cnt = st_q.step_cnt + duty_t'(1);
            end else begin
                st_d.pre_cnt  = st_q.pre_cnt + psc_t'(1);
            end
        end
        // Output follows the state it is registered with
        st_d.led_n = !(st_d.step_cnt < st_d.duty_lim);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{pre_cnt: '0, step_cnt: '0, pre_lim: '0,
                      duty_lim: '0, led_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign led_n_o    = st_q.led_n;
    assign step_o     = st_q.step_cnt;
    assign duty_lim_o = st_q.duty_lim;

endmodule

// File: rtl/blink_pwm_pair.sv
module blink_pwm_pair
    import blink_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned TICK_DIV = 64
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic [NUM_CH-1:0][PSC_W-1:0] psc_i,
    input  logic [NUM_CH-1:0][DUTY_W-1:0] duty_i,
    output logic [NUM_CH-1:0]            blink_n_o
);

    logic                          tick;
    logic [NUM_CH-1:0][DUTY_W-1:0] step_cnt;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty_held;

    blink_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        blink_channel u_ch (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .tick_i     (tick),
            .psc_i      (psc_i[c]),
            .duty_i     (duty_i[c]),
            .led_n_o    (blink_n_o[c]),
            .step_o     (step_cnt[c]),
            .duty_lim_o (duty_held[c])
        );
    end

endmodule

// File: rtl/blink_pwm_pair_chk.sv
module blink_pwm_pair_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DUTY_W = 8
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          tick,
    input logic [NUM_CH-1:0]             blink_n_o,
    input logic [NUM_CH-1:0][DUTY_W-1:0] step_cnt,
    input logic [NUM_CH-1:0][DUTY_W-1:0] duty_held
);

    // R1: outputs are off on the cycle after reset
    assert_off_after_reset_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (blink_n_o == '1));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
        // R4: a held duty of zero never lights the LED
        assert_zero_duty_dark_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            (duty_held[c] == '0) |-> blink_n_o[c]);

        // R2: the step counter moves by at most one, and only on a tick
        assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $past(tick)) |->
            (DUTY_W'(step_cnt[c] - $past(step_cnt[c])) <= DUTY_W'(1)));

        assert_idle_without_tick_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && !$past(tick)) |->
            ($stable(step_cnt[c]) && $stable(blink_n_o[c])));

        // R7: the held duty changes only on a tick at a period start
        assert_duty_at_start_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && (duty_held[c] != $past(duty_held[c]))) |->
            ($past(tick) && ($past(step_cnt[c]) == '0)));
    end

endmodule

bind blink_pwm_pair blink_pwm_pair_chk #(
    .NUM_CH (NUM_CH),
    .DUTY_W (blink_pkg::DUTY_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick      (tick),
    .blink_n_o (blink_n_o),
    .step_cnt  (step_cnt),
    .duty_held (duty_held)
);

// File: tb/blink_pwm_pair_tb_top.sv
module blink_pwm_pair_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [7:0]  p0;
        logic [7:0]  d0;
        logic [7:0]  p1;
        logic [7:0]  d1;
        logic [15:0] ticks;
        logic        e0;
        logic        e1;
    } vec_t;

    // Expected levels follow R3: count = floor(n/(psc+1)) mod 256, 0 when count < duty
    localparam vec_t VECS [NVEC] = '{
        '{8'd0,   8'd128, 8'd1,   8'd5,   16'd10,  1'b0, 1'b1},
        '{8'd0,   8'd128, 8'd0,   8'd129, 16'd128, 1'b1, 1'b0},
        '{8'd0,   8'd128, 8'd0,   8'd0,   16'd127, 1'b0, 1'b1},
        '{8'd0,   8'd255, 8'd1,   8'd200, 16'd255, 1'b1, 1'b0},
        '{8'd0,   8'd255, 8'd3,   8'd64,  16'd254, 1'b0, 1'b0},
        '{8'd3,   8'd2,   8'd0,   8'd7,   16'd7,   1'b0, 1'b1},
        '{8'd3,   8'd2,   8'd0,   8'd9,   16'd8,   1'b1, 1'b0},
        '{8'd0,   8'd0,   8'd0,   8'd255, 16'd5,   1'b1, 1'b0},
        '{8'd0,   8'd1,   8'd1,   8'd1,   16'd256, 1'b0, 1'b1},
        '{8'd0,   8'd1,   8'd255, 8'd1,   16'd257, 1'b1, 1'b1},
        '{8'd1,   8'd200, 8'd0,   8'd44,  16'd300, 1'b0, 1'b1},
        '{8'd255, 8'd1,   8'd0,   8'd255, 16'd255, 1'b0, 1'b1},
        '{8'd255, 8'd1,   8'd2,   8'd100, 16'd256, 1'b1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0][7:0]  psc  = '0;
    logic [1:0][7:0]  duty = '0;
    logic [1:0]       blink_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blink_pwm_pair #(
        .NUM_CH   (2),
        .TICK_DIV (TICK_DIV)
    ) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .psc_i     (psc),
        .duty_i    (duty),
        .blink_n_o (blink_n)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        run_edges(n * TICK_DIV);
    endtask

    initial begin
        // R1: outputs off while reset is held, even with live settings
        psc  = '{8'd0, 8'd0};
        duty = '{8'd255, 8'd255};
        repeat (3) @(negedge clk);
        check(blink_n[0], 1'b1, "R1 ch0 in reset");
        check(blink_n[1], 1'b1, "R1 ch1 in reset");
        rst = 1'b0;

        // R10: no tick yet, still off; R3: one tick later, lit
        run_edges(TICK_DIV - 1);
        check(blink_n[0], 1'b1, "R10 before first tick");
        run_edges(1);
        check(blink_n[0], 1'b0, "R10 R3 after first tick");

        // R1: reset from a lit state turns the outputs off
        do_reset();
        check(blink_n[0], 1'b1, "R1 after reset ch0");
        check(blink_n[1], 1'b1, "R1 after reset ch1");

        // Table: R2 R3 R4 R5 R6 R9 across both channels
        for (int i = 0; i < NVEC; i++) begin
            psc[0]  = VECS[i].p0;
            duty[0] = VECS[i].d0;
            psc[1]  = VECS[i].p1;
            duty[1] = VECS[i].d1;
            do_reset();
            run_ticks(int'(VECS[i].ticks));
            check(blink_n[0], VECS[i].e0, $sformatf("R2 R3 R4 R5 R9 vec %0d ch0", i));
            check(blink_n[1], VECS[i].e1, $sformatf("R3 R6 vec %0d ch1", i));
        end

        // R7: duty change mid-period waits for the next period start
        psc  = '{8'd0, 8'd0};
        duty = '{8'd0, 8'd128};
        do_reset();
        run_ticks(10);
        check(blink_n[0], 1'b0, "R7 before change");
        duty[0] = 8'd0;
        run_ticks(10);
        check(blink_n[0], 1'b0, "R7 change ignored mid-period");
        run_ticks(236);
        check(blink_n[0], 1'b0, "R7 count 0 still old duty");
        run_ticks(1);
        check(blink_n[0], 1'b1, "R7 new duty applied");
        run_ticks(1);
        check(blink_n[0], 1'b1, "R7 R4 new duty holds off");

        // R8: prescaler change mid-period ignored
        psc  = '{8'd0, 8'd0};
        duty = '{8'd0, 8'd12};
        do_reset();
        run_ticks(10);
        check(blink_n[0], 1'b0, "R8 before change");
        psc[0] = 8'd3;
        run_ticks(2);
        check(blink_n[0], 1'b1, "R8 old prescaler kept");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule